// File: doc/BRIEF.md
# Snooping Write-Invalidate Line Coherence Controller

This block tracks the coherence state of a single block in a write-back cache that shares a snooping bus with other caches. It accepts processor reads and writes, each carrying a tag; the hit decision comes from the tag and state the block holds. It also watches the transactions that other caches put on the bus. The block is always in one of three states: invalid, shared (clean and read-only) or exclusive (dirty and writable). Any local write first gains exclusive ownership by placing a write miss or an invalidate on the bus, so every other copy is dropped.

Local hits complete in the cycle they are presented. Any other request is held pending and raises a bus request. The bus operation is recomputed every cycle from the current state, so a pending request adapts when a snooped transaction changes the block underneath it. A dirty block that must be replaced is written back in its own granted bus cycle before the fetch is issued. When another cache misses on a block held dirty here, this cache supplies the data, so memory only answers for blocks that are clean everywhere. The data array, arbiter and memory sit outside the block.

Top module: `coherence_ctrl`

## Requirements
- R1: After reset the block is invalid (line_state 0), bus_req, cpu_done, snp_supply and wb_valid are low.
- R2: A read whose tag matches a shared (1) or exclusive (2) block, or a write whose tag matches an exclusive block, raises cpu_done in the cycle it is presented, raises no bus request and leaves the state unchanged.
- R3: A write whose tag matches a shared block is not completed locally: it issues bus_op 3 (invalidate) with that tag, and the grant cycle raises cpu_done and leaves the block exclusive.
- R4: A request that misses (invalid block, or tag mismatch on a shared block) issues bus_op 1 (read miss) for a read or 2 (write miss) for a write, one cycle after it is presented; the grant raises cpu_done and leaves the block shared after a read or exclusive after a write, holding the new tag.
- R5: A miss that must replace an exclusive block first issues bus_op 4 (write-back) carrying the old tag; its grant raises wb_valid without cpu_done and leaves the block invalid, after which the fetch is issued.
- R6: A snooped read miss (snp_op 1) with a matching tag on an exclusive block raises snp_supply in that cycle and leaves the block shared; on a shared block it raises nothing and changes nothing.
- R7: A snooped write miss (2) or invalidate (3) with a matching tag leaves a valid block invalid; if the block was exclusive, wb_valid is raised in that cycle.
- R8: A snooped transaction whose tag does not match, or that finds the block invalid, changes neither state nor tag and raises neither snp_supply nor wb_valid.
- R9: A local request presented in the same cycle as a snooped transaction that matches the block is not completed in that cycle; it is judged in the next cycle against the state the snoop left.
- R10: A bus grant in a cycle with snp_valid high is not taken: no cpu_done, no state change, and bus_req stays high.
- R11: A pending request re-derives its bus operation each cycle: a pending invalidate whose shared copy is snooped away becomes a write miss, and a pending write-back whose dirty block is snooped (supplied or invalidated) is dropped in favour of the fetch.
- R12: cpu_busy is high in every cycle that cpu_req is held without cpu_done, and bus_req stays high until the request's fetch is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_tag | input | TAG_W | Tag of the requested block |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_busy | output | 1 | Request held and not yet completed |
| bus_req | output | 1 | Bus request for a pending operation |
| bus_op | output | 3 | 0 none, 1 read miss, 2 write miss, 3 invalidate, 4 write-back |
| bus_tag | output | TAG_W | Tag carried by bus_op |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_op | input | 3 | Snooped operation, codes as bus_op (1 to 3) |
| snp_tag | input | TAG_W | Snooped block tag |
| snp_supply | output | 1 | This cache supplies the snooped block's data |
| wb_valid | output | 1 | Dirty data written back this cycle |
| line_state | output | 2 | 0 invalid, 1 shared, 2 exclusive |
| line_tag | output | TAG_W | Tag of the held block |

## Verification
The snoop path and the local request path both act on the same state, and they can meet in one cycle in two ways: a snooped hit arriving with a new local request, and a snooped hit arriving with the bus grant for a pending operation. The bench drives each pair on one clock edge: an invalidate with a read hit on the same tag, an invalidate with a grant for a pending upgrade, and a snooped read miss during a pending write-back. It judges the outcome by checking that no completion appears in the collision cycle, that the snoop's state change is applied, and that the next bus operation reflects the new state (write miss instead of invalidate, fetch instead of write-back).

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_RDMISS = 3'd1,
    OP_WRMISS = 3'd2,
    OP_INVAL  = 3'd3,
    OP_WBACK  = 3'd4
  } bus_op_e;

  // Local request can finish without the bus.
  function automatic logic local_ok(line_st_e st, logic match, logic is_wr);
    return match && ((st == LN_EXC) || ((st == LN_SHR) && !is_wr));
  endfunction

  // Bus operation a pending request needs, given the current block.
  function automatic bus_op_e own_op(line_st_e st, logic match, logic is_wr);
    bus_op_e op;
    if ((st == LN_EXC) && !match)                 op = OP_WBACK;
    else if (is_wr && (st == LN_SHR) && match)    op = OP_INVAL;
    else if (is_wr)                               op = OP_WRMISS;
    else                                          op = OP_RDMISS;
    return op;
  endfunction

  // State after this block's own granted operation.
  function automatic line_st_e grant_state(bus_op_e op, line_st_e st);
    line_st_e nx;
    case (op)
      OP_RDMISS:          nx = LN_SHR;
      OP_WRMISS, OP_INVAL: nx = LN_EXC;
      OP_WBACK:           nx = LN_INV;
      default:            nx = st;
    endcase
    return nx;
  endfunction

  // State after a snooped transaction that matches a valid block.
  function automatic line_st_e snoop_state(bus_op_e op, line_st_e st);
    line_st_e nx;
    case (op)
      OP_RDMISS:           nx = (st == LN_EXC) ? LN_SHR : st;
      OP_WRMISS, OP_INVAL: nx = LN_INV;
      default:             nx = st;
    endcase
    return nx;
  endfunction

  function automatic logic is_snoop_op(bus_op_e op);
    return (op == OP_RDMISS) || (op == OP_WRMISS) || (op == OP_INVAL);
  endfunction

endpackage

// File: rtl/coh_snoop.sv
module coh_snoop
  import coh_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  line_st_e           line_st,
  input  logic [TAG_W-1:0]   line_tag,
  input  logic               snp_valid,
  input  bus_op_e            snp_op,
  input  logic [TAG_W-1:0]   snp_tag,
  output logic               snp_hit,
  output logic               snp_supply,
  output logic               snp_flush,
  output line_st_e           snp_next
);

  logic tag_eq;
  logic kill_op;

  always_comb begin
    tag_eq     = (snp_tag == line_tag);
    snp_hit    = snp_valid && is_snoop_op(snp_op) && (line_st != LN_INV) && tag_eq;
    kill_op    = (snp_op == OP_WRMISS) || (snp_op == OP_INVAL);
    snp_supply = snp_hit && (snp_op == OP_RDMISS) && (line_st == LN_EXC);
    snp_flush  = snp_hit && kill_op && (line_st == LN_EXC);
    snp_next   = snoop_state(snp_op, line_st);
  end

endmodule

// File: rtl/coh_req.sv
module coh_req
  import coh_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [TAG_W-1:0]   cpu_tag,
  input  line_st_e           line_st,
  input  logic [TAG_W-1:0]   line_tag,
  input  logic               snp_hit,
  input  logic               bus_busy,
  input  logic               bus_gnt,
  output logic               hit_done,
  output logic               fill_done,
  output logic               bus_req,
  output bus_op_e            bus_op,
  output logic [TAG_W-1:0]   bus_tag,
  output logic               own_take,
  output line_st_e           take_state,
  output logic [TAG_W-1:0]   take_tag
);

  logic              pending;
  logic              p_we;
  logic [TAG_W-1:0]  p_tag;
  logic              req_match;
  logic              pend_match;
  logic              can_judge;
  logic              accept;
  bus_op_e           cur_op;

  always_comb begin
    req_match  = (line_st != LN_INV) && (cpu_tag == line_tag);
    pend_match = (line_st != LN_INV) && (p_tag == line_tag);
    can_judge  = !pending && cpu_req && !snp_hit;
    hit_done   = can_judge && local_ok(line_st, req_match, cpu_we);
    accept     = can_judge && !local_ok(line_st, req_match, cpu_we);
    cur_op     = pending ? own_op(line_st, pend_match, p_we) : OP_NONE;
    bus_req    = pending;
    bus_op     = cur_op;
    if (!pending)                bus_tag = '0;
    else if (cur_op == OP_WBACK) bus_tag = line_tag;
    else                         bus_tag = p_tag;
    own_take   = pending && bus_gnt && !bus_busy;
    fill_done  = own_take && (cur_op != OP_WBACK);
    take_state = grant_state(cur_op, line_st);
    take_tag   = (cur_op == OP_WBACK) ? line_tag : p_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      p_we    <= 1'b0;
      p_tag   <= '0;
    end else if (accept) begin
      pending <= 1'b1;
      p_we    <= cpu_we;
      p_tag   <= cpu_tag;
    end else if (fill_done) begin
      pending <= 1'b0;
    end
  end

endmodule

// File: rtl/coherence_ctrl.sv
module coherence_ctrl
  import coh_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [TAG_W-1:0]   cpu_tag,
  output logic               cpu_done,
  output logic               cpu_busy,
  output logic               bus_req,
  output logic [2:0]         bus_op,
  output logic [TAG_W-1:0]   bus_tag,
  input  logic               bus_gnt,
  input  logic               snp_valid,
  input  logic [2:0]         snp_op,
  input  logic [TAG_W-1:0]   snp_tag,
  output logic               snp_supply,
  output logic               wb_valid,
  output logic [1:0]         line_state,
  output logic [TAG_W-1:0]   line_tag
);

  line_st_e          st_q;
  logic [TAG_W-1:0]  tag_q;

  // Named internal events, also used by the checker.
  logic              snp_hit;
  logic              snp_flush;
  line_st_e          snp_next;
  logic              hit_done;
  logic              fill_done;
  logic              own_take;
  logic              own_wb;
  line_st_e          take_state;
  logic [TAG_W-1:0]  take_tag;
  bus_op_e           op_w;

  coh_snoop #(.TAG_W(TAG_W)) u_snoop (
    .line_st    (st_q),
    .line_tag   (tag_q),
    .snp_valid  (snp_valid),
    .snp_op     (bus_op_e'(snp_op)),
    .snp_tag    (snp_tag),
    .snp_hit    (snp_hit),
    .snp_supply (snp_supply),
    .snp_flush  (snp_flush),
    .snp_next   (snp_next)
  );

  coh_req #(.TAG_W(TAG_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_tag    (cpu_tag),
    .line_st    (st_q),
    .line_tag   (tag_q),
    .snp_hit    (snp_hit),
    .bus_busy   (snp_valid),
    .bus_gnt    (bus_gnt),
    .hit_done   (hit_done),
    .fill_done  (fill_done),
    .bus_req    (bus_req),
    .bus_op     (op_w),
    .bus_tag    (bus_tag),
    .own_take   (own_take),
    .take_state (take_state),
    .take_tag   (take_tag)
  );

  always_comb begin
    bus_op     = op_w;
    own_wb     = own_take && (op_w == OP_WBACK);
    wb_valid   = own_wb || snp_flush;
    cpu_done   = hit_done || fill_done;
    cpu_busy   = cpu_req && !cpu_done;
    line_state = st_q;
    line_tag   = tag_q;
  end

  // Snooped transactions and own grants never share a cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= LN_INV;
      tag_q <= '0;
    end else if (snp_hit) begin
      st_q  <= snp_next;
    end else if (own_take) begin
      st_q  <= take_state;
      tag_q <= take_tag;
    end
  end

endmodule

// File: rtl/coh_checker.sv
module coh_checker #(
  parameter int TAG_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              own_take,
  input logic [2:0]        bus_op,
  input logic [1:0]        line_state,
  input logic [TAG_W-1:0]  line_tag,
  input logic              snp_valid,
  input logic [2:0]        snp_op,
  input logic [TAG_W-1:0]  snp_tag,
  input logic              snp_supply
);

  AST_RD_FILL_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    own_take && (bus_op == 3'd1) |=> (line_state == 2'd1)); // R4

  AST_WR_FILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    own_take && ((bus_op == 3'd2) || (bus_op == 3'd3)) |=> (line_state == 2'd2)); // R3

  AST_WB_EVICTS: assert property (@(posedge clk) disable iff (!rst_n)
    own_take && (bus_op == 3'd4) |=> (line_state == 2'd0)); // R5

  AST_WB_BEFORE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    own_take && ((bus_op == 3'd1) || (bus_op == 3'd2)) |-> (line_state != 2'd2)); // R5

  AST_SUPPLY_TO_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |=> (line_state == 2'd1)); // R6

  AST_SNOOP_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && ((snp_op == 3'd2) || (snp_op == 3'd3)) && (line_state != 2'd0)
      && (snp_tag == line_tag) |=> (line_state == 2'd0)); // R7

  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && (snp_tag != line_tag) |=> $stable(line_state) && $stable(line_tag)); // R8

  AST_ONE_BUS_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !own_take); // R10

endmodule

bind coherence_ctrl coh_checker #(.TAG_W(TAG_W)) u_coh_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .own_take   (own_take),
  .bus_op     (bus_op),
  .line_state (line_state),
  .line_tag   (line_tag),
  .snp_valid  (snp_valid),
  .snp_op     (snp_op),
  .snp_tag    (snp_tag),
  .snp_supply (snp_supply)
);

// File: tb/tb_coherence_ctrl.sv
module tb_coherence_ctrl;

  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req, cpu_we;
  logic [TW-1:0] cpu_tag;
  logic          cpu_done, cpu_busy, bus_req;
  logic [2:0]    bus_op;
  logic [TW-1:0] bus_tag;
  logic          bus_gnt, snp_valid;
  logic [2:0]    snp_op;
  logic [TW-1:0] snp_tag;
  logic          snp_supply, wb_valid;
  logic [1:0]    line_state;
  logic [TW-1:0] line_tag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [TW-1:0] TA = 8'h1A, TB = 8'h2B, TC = 8'h3C, TD = 8'h4D, TF = 8'h5F;

  always #5 clk = ~clk;

  coherence_ctrl #(.TAG_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tag(cpu_tag),
    .cpu_done(cpu_done), .cpu_busy(cpu_busy), .bus_req(bus_req), .bus_op(bus_op),
    .bus_tag(bus_tag), .bus_gnt(bus_gnt), .snp_valid(snp_valid), .snp_op(snp_op),
    .snp_tag(snp_tag), .snp_supply(snp_supply), .wb_valid(wb_valid),
    .line_state(line_state), .line_tag(line_tag)
  );

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic idle_in();
    cpu_req = 0; cpu_we = 0; cpu_tag = '0; bus_gnt = 0;
    snp_valid = 0; snp_op = '0; snp_tag = '0;
  endtask

  // Request that needs the bus: accept, wait, grant.
  task automatic miss_fill(bit we, logic [TW-1:0] tg, int exp_op, int waits, string rq);
    @(negedge clk); cpu_req = 1; cpu_we = we; cpu_tag = tg; #1;
    chk({rq, " no done on accept"}, cpu_done, 0);
    chk({rq, " busy on accept"}, cpu_busy, 1);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk); #1;
      chk("R12 bus_req held", bus_req, 1);
      chk("R12 busy held", cpu_busy, 1);
    end
    @(negedge clk); bus_gnt = 1; #1;
    chk({rq, " bus_op"}, bus_op, exp_op);
    chk({rq, " bus_tag"}, bus_tag, tg);
    chk({rq, " done on grant"}, cpu_done, 1);
    @(negedge clk); idle_in(); #1;
    chk({rq, " bus_req drops"}, bus_req, 0);
  endtask

  task automatic local_hit(bit we, logic [TW-1:0] tg, int st);
    @(negedge clk); cpu_req = 1; cpu_we = we; cpu_tag = tg; #1;
    chk("R2 hit done", cpu_done, 1);
    chk("R2 hit no bus", bus_req, 0);
    @(negedge clk); idle_in(); #1;
    chk("R2 state kept", line_state, st);
    chk("R2 no bus after", bus_req, 0);
  endtask

  task automatic t_reset();
    idle_in(); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk("R1 state", line_state, 0);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 done", cpu_done, 0);
    chk("R1 supply", snp_supply, 0);
    chk("R1 wb", wb_valid, 0);
  endtask

  task automatic t_read_write_basic();
    miss_fill(0, TA, 1, 2, "R4 read miss");
    chk("R4 shared", line_state, 1);
    chk("R4 tag", line_tag, TA);
    local_hit(0, TA, 1);
    miss_fill(1, TA, 3, 1, "R3 upgrade");
    chk("R3 exclusive", line_state, 2);
    local_hit(1, TA, 2);
    local_hit(0, TA, 2);
  endtask

  task automatic t_snoop_basic();
    @(negedge clk); snp_valid = 1; snp_op = 3'd1; snp_tag = TA; #1;
    chk("R6 supply from E", snp_supply, 1);
    chk("R6 no wb", wb_valid, 0);
    @(negedge clk); idle_in(); snp_valid = 1; snp_op = 3'd1; snp_tag = TA; #1;
    chk("R6 shared after supply", line_state, 1);
    chk("R6 no supply from S", snp_supply, 0);
    @(negedge clk); snp_op = 3'd2; snp_tag = TB; #1;
    chk("R6 S kept", line_state, 1);
    chk("R8 no wb on mismatch", wb_valid, 0);
    @(negedge clk); snp_op = 3'd3; snp_tag = TA; #1;
    chk("R8 mismatch kept S", line_state, 1);
    chk("R7 no wb from S", wb_valid, 0);
    @(negedge clk); snp_op = 3'd1; snp_tag = TA; #1;
    chk("R7 invalid after inval", line_state, 0);
    chk("R8 no supply when invalid", snp_supply, 0);
    @(negedge clk); idle_in(); #1;
    chk("R8 still invalid", line_state, 0);
  endtask

  task automatic t_snoop_flush();
    miss_fill(1, TB, 2, 0, "R4 write miss");
    chk("R4 exclusive", line_state, 2);
    chk("R4 tag B", line_tag, TB);
    @(negedge clk); snp_valid = 1; snp_op = 3'd2; snp_tag = TB; #1;
    chk("R7 flush wb", wb_valid, 1);
    @(negedge clk); idle_in(); #1;
    chk("R7 invalid after flush", line_state, 0);
  endtask

  task automatic t_replace();
    miss_fill(1, TC, 2, 0, "R4 write miss C");
    @(negedge clk); cpu_req = 1; cpu_we = 0; cpu_tag = TD; #1;
    chk("R5 no done", cpu_done, 0);
    @(negedge clk); bus_gnt = 1; #1;
    chk("R5 op writeback", bus_op, 4);
    chk("R5 old tag", bus_tag, TC);
    chk("R5 wb_valid", wb_valid, 1);
    chk("R5 no done on wb", cpu_done, 0);
    @(negedge clk); bus_gnt = 0; #1;
    chk("R5 invalid after wb", line_state, 0);
    chk("R5 fetch op", bus_op, 1);
    chk("R5 fetch tag", bus_tag, TD);
    @(negedge clk); bus_gnt = 1; #1;
    chk("R5 done on fetch", cpu_done, 1);
    @(negedge clk); idle_in(); #1;
    chk("R5 shared D", line_state, 1);
    chk("R5 tag D", line_tag, TD);
  endtask

  task automatic t_collide_request();
    @(negedge clk); cpu_req = 1; cpu_we = 0; cpu_tag = TD;
    snp_valid = 1; snp_op = 3'd3; snp_tag = TD; #1;
    chk("R9 no done with snoop", cpu_done, 0);
    @(negedge clk); snp_valid = 0; snp_op = 0; snp_tag = 0; #1;
    chk("R9 snoop applied", line_state, 0);
    chk("R9 judged as miss", cpu_done, 0);
    @(negedge clk); bus_gnt = 1; #1;
    chk("R9 read miss issued", bus_op, 1);
    chk("R9 done on grant", cpu_done, 1);
    @(negedge clk); idle_in(); #1;
    chk("R9 shared again", line_state, 1);
  endtask

  task automatic t_collide_grant();
    @(negedge clk); cpu_req = 1; cpu_we = 1; cpu_tag = TD; #1;
    @(negedge clk); #1;
    chk("R3 pending inval", bus_op, 3);
    @(negedge clk); bus_gnt = 1; snp_valid = 1; snp_op = 3'd3; snp_tag = TD; #1;
    chk("R10 grant ignored", cpu_done, 0);
    chk("R10 bus_req kept", bus_req, 1);
    @(negedge clk); bus_gnt = 0; snp_valid = 0; snp_op = 0; snp_tag = 0; #1;
    chk("R10 no grant effect", line_state, 0);
    chk("R11 becomes write miss", bus_op, 2);
    @(negedge clk); bus_gnt = 1; #1;
    chk("R11 done", cpu_done, 1);
    @(negedge clk); idle_in(); #1;
    chk("R11 exclusive", line_state, 2);
    chk("R11 tag D", line_tag, TD);
  endtask

  task automatic t_wb_dropped();
    @(negedge clk); cpu_req = 1; cpu_we = 0; cpu_tag = TF; #1;
    @(negedge clk); snp_valid = 1; snp_op = 3'd1; snp_tag = TD; #1;
    chk("R11 pending wb", bus_op, 4);
    chk("R11 supply", snp_supply, 1);
    @(negedge clk); snp_valid = 0; snp_op = 0; snp_tag = 0; #1;
    chk("R11 wb dropped", bus_op, 1);
    chk("R11 fetch tag", bus_tag, TF);
    @(negedge clk); bus_gnt = 1; #1;
    chk("R11 no wb data", wb_valid, 0);
    chk("R11 fetch done", cpu_done, 1);
    @(negedge clk); idle_in(); #1;
    chk("R11 shared F", line_state, 1);
    chk("R11 tag F", line_tag, TF);
  endtask

  initial begin
    t_reset();
    t_read_write_basic();
    t_snoop_basic();
    t_snoop_flush();
    t_replace();
    t_collide_request();
    t_collide_grant();
    t_wb_dropped();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule